// File: doc/BRIEF.md
# ULPI Link-Side Register Access Sequencer

This block sits on the link side of an 8-bit ULPI bus and carries out register writes and register reads on a PHY through the bus data byte, the direction line, the stop line and the next line. A requester raises a request with an address, a write flag and a write byte. The requester holds the request until the block pulses either a done flag or an aborted flag. On a completed read, the byte returned by the PHY is on the read-data output.

Before any transaction can run, the block waits out a power-up interval. The interval begins when the PHY power-off input goes low. During the interval the block leaves the data bus undriven and ignores both the direction line and any pending request. The interval length is a parameter counted in clock cycles; at 60 MHz the default is 1 ms.

After the interval, the block drives the idle byte 00h whenever it owns the bus. It releases the bus whenever the PHY raises the direction line. If the PHY takes the bus in the middle of a register transaction, the block cancels that transaction and reports it as aborted.

Top module: `ulpi_reg_seq`

## Requirements
- R1: While reset is held, and for WAKE_CYCLES clock edges after the first edge that samples phy_off low, ulpi_data_oe stays 0 and no transaction starts, whatever ulpi_dir and req_valid do. After the next edge the bus is driven with 00h.
- R2: Raising phy_off returns the block to the power-up wait. ulpi_data_oe is 0 after the next edge, and the full wait of R1 is repeated once phy_off falls again.
- R3: After the wait, with no transaction running and ulpi_dir low, the block drives ulpi_data_out = 00h with ulpi_data_oe = 1 and ulpi_stp = 0.
- R4: A write begins with the command byte {2'b10, address[5:0]} on the bus. A read begins with the command byte {2'b11, address[5:0]}. The command byte is held unchanged for as long as ulpi_nxt is sampled low.
- R5: In a write, after ulpi_nxt acknowledges the command, the write byte is driven until ulpi_nxt is sampled high. ulpi_stp is then high for exactly one cycle with the bus at 00h, and done pulses for one cycle on the next edge. With a PHY that answers at once, done is visible 4 cycles after the request is raised, plus one cycle for each cycle of stall.
- R6: In a read, the bus is released on the edge that samples ulpi_nxt high. The block captures ulpi_data_in on the edge after the first edge that samples ulpi_dir high, drives it on rd_data and pulses done on that same edge. It then waits for ulpi_dir to fall. With a prompt PHY, done is visible 4 cycles after the request, plus the stall cycles.
- R7: If ulpi_dir is sampled high while a command byte or a write byte is being presented, the transaction ends on that edge. aborted pulses instead of done, ulpi_stp is never raised, and the PHY register is left unchanged.
- R8: While ulpi_dir is high and the block is idle, a pending request is not started and ulpi_data_oe is 0. The request starts on the first edge that samples ulpi_dir low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_off | input | 1 | High while the PHY is powered down; its falling edge starts the power-up wait |
| req_valid | input | 1 | Request pending; held until done or aborted |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 6 | Register address |
| req_wdata | input | 8 | Byte to write |
| rd_data | output | 8 | Byte returned by the last completed read |
| done | output | 1 | One-cycle pulse: the transaction completed |
| aborted | output | 1 | One-cycle pulse: the PHY took the bus and the transaction was cancelled |
| ulpi_data_in | input | 8 | Bus byte as driven by the PHY |
| ulpi_data_out | output | 8 | Bus byte driven by the link |
| ulpi_data_oe | output | 1 | Link output enable for the data bus |
| ulpi_dir | input | 1 | Bus direction from the PHY; high = PHY owns the bus |
| ulpi_nxt | input | 1 | PHY throttle / acknowledge |
| ulpi_stp | output | 1 | Stop strobe ending a write |

## Verification
The PHY model is stimulated on falling clock edges. A request raised on one falling edge is accepted on the next rising edge, so with a prompt PHY a write or read reports done on the fourth falling edge after the request. Each PHY stall cycle adds one to that count. An abort at the command byte is reported on the second falling edge and an abort at the write byte on the third. The driver counts falling edges from the request to the flag and compares the count with these figures. The power-up checks sample the bus once per falling edge, expect it released for WAKE_CYCLES samples after phy_off falls, and expect it driven with 00h on the sample after that.

// File: rtl/ulpi_seq_pkg.sv
package ulpi_seq_pkg;

    localparam int DATA_W = 8;
    localparam int CODE_W = 2;
    localparam int ADDR_W = DATA_W - CODE_W;

    localparam logic [CODE_W-1:0] CMD_REGW = 2'b10;
    localparam logic [CODE_W-1:0] CMD_REGR = 2'b11;

    typedef enum logic [3:0] {
        S_WAIT,
        S_IDLE,
        S_WCMD,
        S_WDAT,
        S_WSTP,
        S_RCMD,
        S_RDIR,
        S_RCAP,
        S_REND
    } seq_state_e;

    typedef struct packed {
        seq_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                done;
        logic                aborted;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        st:      S_WAIT,
        addr:    '0,
        wdata:   '0,
        rdata:   '0,
        done:    1'b0,
        aborted: 1'b0
    };

endpackage

// File: rtl/ulpi_wake_timer.sv
module ulpi_wake_timer #(
    parameter int WAKE_CYCLES = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phy_off,
    output logic wake_done
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAKE_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (phy_off) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign wake_done = (cnt_q == CNT_MAX);

    // R2
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_off |=> !wake_done);

endmodule

// File: rtl/ulpi_reg_fsm.sv
module ulpi_reg_fsm
    import ulpi_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_off,
    input  logic              wake_done,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              aborted,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              dir,
    input  logic              nxt,
    output logic              stp
);
    seq_regs_t q, d;
    logic owns_bus;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.aborted = 1'b0;
        if (phy_off) begin
            d.st = S_WAIT;
        end else begin
            case (q.st)
                S_WAIT: if (wake_done) d.st = S_IDLE;
                S_IDLE: begin
                    if (req_valid && !dir) begin
                        d.addr  = req_addr;
                        d.wdata = req_wdata;
                        d.st    = req_write ? S_WCMD : S_RCMD;
                    end
                end
                S_WCMD: begin
                    if (dir) begin
                        d.st      = S_IDLE;
                        d.aborted = 1'b1;
                    end else if (nxt) begin
                        d.st = S_WDAT;
                    end
                end
                S_WDAT: begin
                    if (dir) begin
                        d.st      = S_IDLE;
                        d.aborted = 1'b1;
                    end else if (nxt) begin
                        d.st = S_WSTP;
                    end
                end
                S_WSTP: begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end
                S_RCMD: begin
                    if (dir) begin
                        d.st      = S_IDLE;
                        d.aborted = 1'b1;
                    end else if (nxt) begin
                        d.st = S_RDIR;
                    end
                end
                S_RDIR: if (dir) d.st = S_RCAP;
                S_RCAP: begin
                    d.rdata = data_in;
                    d.done  = 1'b1;
                    d.st    = S_REND;
                end
                S_REND: if (!dir) d.st = S_IDLE;
                default: d.st = S_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEQ_RESET;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            S_WCMD:  data_out = {CMD_REGW, q.addr};
            S_WDAT:  data_out = q.wdata;
            S_RCMD:  data_out = {CMD_REGR, q.addr};
            default: data_out = '0;
        endcase
    end

    assign owns_bus = q.st inside {S_IDLE, S_WCMD, S_WDAT, S_WSTP, S_RCMD};
    assign data_oe  = owns_bus && !dir;
    assign stp      = (q.st == S_WSTP);
    assign rd_data  = q.rdata;
    assign done     = q.done;
    assign aborted  = q.aborted;

    // R7
    abort_on_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st inside {S_WCMD, S_WDAT, S_RCMD}) && dir && !phy_off)
        |=> (aborted && !done && !stp));

    // R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st inside {S_WCMD, S_RCMD}) && !nxt && !dir && !phy_off)
        |=> $stable(data_out));

    // R5
    stp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stp |=> !stp);

    // R6
    read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == S_RCAP) && !phy_off) |=> (done && rd_data == $past(data_in)));

endmodule

// File: rtl/ulpi_reg_seq.sv
module ulpi_reg_seq
    import ulpi_seq_pkg::*;
#(
    parameter int WAKE_CYCLES = 60000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_off,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              aborted,
    input  logic [DATA_W-1:0] ulpi_data_in,
    output logic [DATA_W-1:0] ulpi_data_out,
    output logic              ulpi_data_oe,
    input  logic              ulpi_dir,
    input  logic              ulpi_nxt,
    output logic              ulpi_stp
);
    logic wake_done;

    ulpi_wake_timer #(
        .WAKE_CYCLES(WAKE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_off   (phy_off),
        .wake_done (wake_done)
    );

    ulpi_reg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_off   (phy_off),
        .wake_done (wake_done),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .done      (done),
        .aborted   (aborted),
        .data_in   (ulpi_data_in),
        .data_out  (ulpi_data_out),
        .data_oe   (ulpi_data_oe),
        .dir       (ulpi_dir),
        .nxt       (ulpi_nxt),
        .stp       (ulpi_stp)
    );

    // R1
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_done |-> (!ulpi_data_oe && !done && !aborted));

endmodule

// File: tb/tb_ulpi_reg_seq.sv
`timescale 1ns/1ps
module tb_ulpi_reg_seq;
    localparam int WAKE = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phy_off = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [5:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] rd_data;
    logic       done, aborted;
    logic [7:0] ulpi_data_in = '0;
    logic [7:0] ulpi_data_out;
    logic       ulpi_data_oe;
    logic       ulpi_dir;
    logic       ulpi_nxt = 1'b0;
    logic       ulpi_stp;
    logic       phy_dir = 1'b0;
    logic       hold_dir = 1'b0;

    assign ulpi_dir = phy_dir | hold_dir;

    ulpi_reg_seq #(.WAKE_CYCLES(WAKE)) dut (
        .clk(clk), .rst_n(rst_n), .phy_off(phy_off),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .aborted(aborted),
        .ulpi_data_in(ulpi_data_in), .ulpi_data_out(ulpi_data_out),
        .ulpi_data_oe(ulpi_data_oe), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
        .ulpi_stp(ulpi_stp)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic       wr;
        logic       abt;
        logic [5:0] a;
        logic [7:0] exp;
    } op_t;
    op_t sb[$];

    logic [7:0] shadow [64];
    logic [7:0] phy_regs [64];

    // PHY model state
    int         stall_cfg = 0;
    int         abort_mode = 0;
    int         pst = 0;
    int         pwait = 0;
    int         ahold = 0;
    logic [7:0] pcmd = '0;
    logic [7:0] pdata = '0;
    logic [7:0] last_cmd = '0;
    bit         stp_seen = 1'b0;

    task automatic phy_act();
        if (abort_mode == 1) begin
            ulpi_nxt = 1'b0;
            phy_dir  = 1'b1;
            ahold    = 3;
            pst      = 5;
        end else begin
            ulpi_nxt = 1'b1;
            pst      = pcmd[6] ? 6 : 2;
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            case (pst)
                0: begin
                    ulpi_nxt = 1'b0;
                    if (ulpi_data_oe && ulpi_data_out != 8'h00) begin
                        pcmd     = ulpi_data_out;
                        last_cmd = ulpi_data_out;
                        stp_seen = 1'b0;
                        pwait    = stall_cfg;
                        if (pwait == 0) phy_act();
                        else pst = 1;
                    end
                end
                1: begin
                    check(ulpi_data_oe && ulpi_data_out == pcmd, "R4",
                          "command byte held during stall", ulpi_data_out, pcmd);
                    pwait--;
                    if (pwait == 0) phy_act();
                end
                2: begin
                    if (abort_mode == 2) begin
                        ulpi_nxt = 1'b0;
                        phy_dir  = 1'b1;
                        ahold    = 3;
                        pst      = 5;
                    end else begin
                        pdata    = ulpi_data_out;
                        ulpi_nxt = 1'b1;
                        pst      = 3;
                    end
                end
                3: begin
                    ulpi_nxt = 1'b0;
                    check(ulpi_stp == 1'b1 && ulpi_data_out == 8'h00, "R5",
                          "stop strobe with idle byte", {ulpi_stp, ulpi_data_out}, 9'h100);
                    if (ulpi_stp) begin
                        stp_seen = 1'b1;
                        phy_regs[pcmd[5:0]] = pdata;
                    end
                    pst = 0;
                end
                5: begin
                    if (ulpi_stp) stp_seen = 1'b1;
                    ahold--;
                    if (ahold == 0) begin
                        phy_dir = 1'b0;
                        pst     = 0;
                    end
                end
                6: begin
                    ulpi_nxt = 1'b0;
                    check(!ulpi_data_oe, "R6", "bus released after acknowledge",
                          ulpi_data_oe, 0);
                    phy_dir = 1'b1;
                    pst     = 7;
                end
                7: begin
                    ulpi_data_in = phy_regs[pcmd[5:0]];
                    pst          = 8;
                end
                8: begin
                    phy_dir      = 1'b0;
                    ulpi_data_in = 8'h00;
                    pst          = 0;
                end
                default: pst = 0;
            endcase
        end
    end

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (done || aborted) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5", "unexpected completion flag", {done, aborted}, 0);
                end else begin
                    op_t it;
                    string tg;
                    it = sb.pop_front();
                    tg = it.abt ? "R7" : (it.wr ? "R5" : "R6");
                    check(aborted == it.abt && done == !it.abt, tg,
                          "done/aborted flags", {done, aborted}, {!it.abt, it.abt});
                    check(last_cmd == {it.wr ? 2'b10 : 2'b11, it.a}, "R4",
                          "command byte", last_cmd, {it.wr ? 2'b10 : 2'b11, it.a});
                    if (it.wr)
                        check(phy_regs[it.a] == it.exp, tg, "PHY register contents",
                              phy_regs[it.a], it.exp);
                    else if (!it.abt)
                        check(rd_data == it.exp, "R6", "read data", rd_data, it.exp);
                    if (it.abt)
                        check(!stp_seen, "R7", "no stop strobe on abort", stp_seen, 0);
                end
            end
        end
    end

    task automatic run_op(input bit wr, input logic [5:0] a, input logic [7:0] wd,
                          input int stall, input int amode, input int hold,
                          input int exp_lat);
        op_t it;
        int lat;
        it.wr  = wr;
        it.abt = (amode != 0);
        it.a   = a;
        it.exp = (wr && amode == 0) ? wd : shadow[a];
        if (wr && amode == 0) shadow[a] = wd;
        sb.push_back(it);
        stall_cfg  = stall;
        abort_mode = amode;
        req_write  = wr;
        req_addr   = a;
        req_wdata  = wd;
        req_valid  = 1'b1;
        if (hold > 0) begin
            hold_dir = 1'b1;
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                check(!ulpi_data_oe && !done && !aborted, "R8",
                      "request waits while PHY owns bus",
                      {ulpi_data_oe, done, aborted}, 0);
            end
            hold_dir = 1'b0;
        end
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!(done || aborted) && lat < 200);
        req_valid = 1'b0;
        if (lat >= 200) begin
            check(1'b0, "R5", "transaction timeout", lat, exp_lat);
            sb.delete();
        end else begin
            check(lat == exp_lat, it.abt ? "R7" : (wr ? "R5" : "R6"),
                  "cycles to completion flag", lat, exp_lat);
        end
        abort_mode = 0;
        stall_cfg  = 0;
        repeat (5) @(negedge clk);
        check(ulpi_data_oe && ulpi_data_out == 8'h00 && !ulpi_stp, "R3",
              "idle bus byte", {ulpi_data_oe, ulpi_data_out, ulpi_stp}, 10'h200);
    endtask

    task automatic wake_check(input string tg, input bit poke);
        for (int i = 1; i <= WAKE; i++) begin
            @(negedge clk);
            check(!ulpi_data_oe && !done && !aborted, tg, "bus released during wait",
                  {ulpi_data_oe, done, aborted}, 0);
            if (poke && i == 3) hold_dir = 1'b1;
            if (poke && i == 8) hold_dir = 1'b0;
            if (i == WAKE) req_valid = 1'b0;
        end
        @(negedge clk);
        check(ulpi_data_oe && ulpi_data_out == 8'h00, tg, "bus driven idle after wait",
              {ulpi_data_oe, ulpi_data_out}, 9'h100);
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            phy_regs[i] = 8'(i * 3 + 8'h41);
            shadow[i]   = 8'(i * 3 + 8'h41);
        end
        repeat (4) @(negedge clk);
        check(!ulpi_data_oe && !ulpi_stp && !done && !aborted, "R1", "reset state",
              {ulpi_data_oe, ulpi_stp, done, aborted}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!ulpi_data_oe, "R1", "bus released while powered off", ulpi_data_oe, 0);

        // R1: wait with a pending write request and a direction pulse
        phy_off   = 1'b0;
        req_write = 1'b1;
        req_addr  = 6'd9;
        req_wdata = 8'hEE;
        req_valid = 1'b1;
        wake_check("R1", 1'b1);
        @(negedge clk);
        check(ulpi_data_oe && ulpi_data_out == 8'h00, "R3", "idle after wait",
              {ulpi_data_oe, ulpi_data_out}, 9'h100);
        check(phy_regs[9] == shadow[9], "R1", "request ignored during wait",
              phy_regs[9], shadow[9]);

        // R5 / R6 / R4 main traffic
        run_op(1'b1, 6'd3,  8'h5A, 0, 0, 0, 4);
        run_op(1'b0, 6'd3,  8'h00, 0, 0, 0, 4);
        run_op(1'b1, 6'd63, 8'hC3, 3, 0, 0, 7);
        run_op(1'b0, 6'd63, 8'h00, 2, 0, 0, 6);
        run_op(1'b0, 6'd0,  8'h00, 0, 0, 0, 4);

        // R7 aborts
        run_op(1'b1, 6'd10, 8'h77, 0, 1, 0, 2);
        run_op(1'b1, 6'd11, 8'h99, 0, 2, 0, 3);
        run_op(1'b0, 6'd11, 8'h00, 0, 0, 0, 4);
        run_op(1'b0, 6'd3,  8'h00, 0, 1, 0, 2);
        run_op(1'b1, 6'd12, 8'h13, 2, 1, 0, 4);
        run_op(1'b0, 6'd10, 8'h00, 0, 0, 0, 4);

        // R8 request held back while the PHY owns the bus
        run_op(1'b1, 6'd20, 8'hA5, 0, 0, 4, 4);
        run_op(1'b0, 6'd20, 8'h00, 0, 0, 3, 4);

        // R2 power-off returns to the wait
        phy_off = 1'b1;
        @(negedge clk);
        check(!ulpi_data_oe, "R2", "bus released on power-off", ulpi_data_oe, 0);
        repeat (3) @(negedge clk);
        phy_off = 1'b0;
        wake_check("R2", 1'b0);
        run_op(1'b1, 6'd33, 8'h3C, 1, 0, 0, 5);
        run_op(1'b0, 6'd33, 8'h00, 0, 0, 0, 4);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule